// File: doc/BRIEF.md
# L2 Request Address Classifier

This block sits in front of the tag and data pipeline of a four-way, 32-byte-line L2 cache. It looks at the physical address of each request and sorts it into one of three classes in the same cycle. A configuration write is a write to one fixed address. The four address bits just above the low byte carry a new cache-size setting, and the write's data has no meaning. A management access falls in a reserved 128 MB address window. Such a request must always hit, whatever its cacheable attribute says, and the memory controller must ignore it. Any other valid request is a normal access.

The block holds a hidden 4-bit size register that configuration writes load. For normal accesses it uses that register to pin the top one or two set-index bits. This shrinks the cache from 512 KB to 256 KB or 128 KB while it keeps four ways. For management accesses it passes the raw set index through unchanged. It also returns a way number taken from the two address bits just above the index. The register's value is always visible on a readback output.

Top module: `l2_addr_classifier`

## Requirements
- R1: After reset the size register reads back 0, which means the full 512 KB cache.
- R2: A valid write whose address equals 0x00_1004_2000 in every bit except bits [11:8] loads bits [11:8] into the size register. The readback shows the new value from the next clock edge on, and not before. A read of that address, or a write that differs in any other bit, loads nothing.
- R3: With register value 0, the index output equals address bits [16:5] for normal accesses.
- R4: The register is split into two 2-bit fields. Field value 1 forces an index bit to 0 and field value 2 forces it to 1. Bits [1:0] act on index bit 11 and bits [3:2] act on index bit 10. Register values 1 and 2 therefore give a 256 KB cache and change only index bit 11.
- R5: Register values 5, 6, 9 and 0xA force both index bits: 5 gives bit11=0 and bit10=0, 6 gives bit11=1 and bit10=0, 9 gives bit11=0 and bit10=1, and 0xA gives bit11=1 and bit10=1.
- R6: The output cfg_unsupported is high exactly when the register holds a value other than 0, 1, 2, 5, 6, 9 or 0xA.
- R7: A valid request with an address from 0x00_D000_0000 to 0x00_D7FF_FFFF is a management access. It asserts is_mgmt, force_hit and mc_ignore, and eff_cacheable is 1 even when req_cacheable is 0.
- R8: For a management access, mgmt_way equals address bits [18:17], and the index output is the unrestricted address bits [16:5] whatever the register holds.
- R9: While req_vld is high, exactly one of is_cfg_wr, is_mgmt and is_normal is high. While req_vld is low, all three are low, and so are force_hit, mc_ignore and fwd_vld.
- R10: fwd_vld is low for a configuration write and high for every other valid request.
- R11: The size register keeps its value across all requests that are not configuration writes, management traffic included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 40 | Physical byte address |
| req_cacheable | input | 1 | Cacheable attribute from the requester |
| idx_out | output | 12 | Effective set index |
| mgmt_way | output | 2 | Way chosen by a management access |
| is_cfg_wr | output | 1 | Request is a size-register write |
| is_mgmt | output | 1 | Request is a management access |
| is_normal | output | 1 | Request is an ordinary access |
| force_hit | output | 1 | Lookup must report a hit |
| mc_ignore | output | 1 | Memory controller must drop the request |
| eff_cacheable | output | 1 | Cacheable attribute after the override |
| fwd_vld | output | 1 | Request is passed on to the cache |
| cfg_readback | output | 4 | Current size register value |
| cfg_unsupported | output | 1 | Size register holds an undefined setting |

## Verification
The index is driven with several address patterns under every supported register value. These include all-ones and all-zeros index fields and alternating bit patterns, so a forced bit pointing the wrong way or acting on the wrong index bit gives a visible mismatch. Addresses are placed one byte inside and one byte outside each end of the management window, and next to the configuration address with a single bit flipped. This separates an off-by-one range compare and a sloppy address match from correct decoding. Management requests are sent while the cache is set to 128 KB, which shows whether the restriction leaks into the raw management index. Reads to the configuration address and management traffic are interleaved with register writes, which tells a register that loads on the wrong condition apart from one that holds.

// File: rtl/l2cls_pkg.sv
package l2cls_pkg;

  // A 2-bit size field pins its index bit when it holds 1 or 2.
  function automatic logic fld_active(input logic [1:0] f);
    return (f == 2'd1) || (f == 2'd2);
  endfunction

  // Level written into the pinned index bit: 1 -> low, 2 -> high.
  function automatic logic fld_level(input logic [1:0] f);
    return f[1];
  endfunction

  // A field of 3 is undefined.
  function automatic logic fld_bad(input logic [1:0] f);
    return f == 2'd3;
  endfunction

endpackage

// File: rtl/l2cls_sizereg.sv
module l2cls_sizereg #(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CFG_W-1:0] load_val,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (load_en) cfg_q <= load_val;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == '0));

  assert_load_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cfg_q == $past(load_val)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cfg_q));

endmodule

// File: rtl/l2cls_addr_match.sv
module l2cls_addr_match #(
  parameter int          ADDR_W     = 40,
  parameter logic [39:0] CFG_ADDR   = 40'h00_1004_2000,
  parameter int          CFG_LSB    = 8,
  parameter int          CFG_W      = 4,
  parameter logic [39:0] MGMT_BASE  = 40'h00_D000_0000,
  parameter int          MGMT_LOG2  = 27,
  parameter int          WAY_LSB    = 17,
  parameter int          WAY_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              cfg_hit,
  output logic [CFG_W-1:0]  cfg_nib,
  output logic              mgmt_hit,
  output logic [WAY_W-1:0]  way_sel
);

  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  logic [ADDR_W-1:0] cfg_mask;
  always_comb begin
    cfg_mask = '1;
    cfg_mask[CFG_MSB:CFG_LSB] = '0;
  end

  // Every bit outside the control nibble must match the configuration address.
  assign cfg_hit  = ((addr ^ CFG_ADDR[ADDR_W-1:0]) & cfg_mask) == '0;
  assign cfg_nib  = addr[CFG_MSB:CFG_LSB];
  // The window is aligned to its size, so only the upper bits are compared.
  assign mgmt_hit = addr[ADDR_W-1:MGMT_LOG2] == MGMT_BASE[ADDR_W-1:MGMT_LOG2];
  assign way_sel  = addr[WAY_LSB+WAY_W-1:WAY_LSB];

  always_comb begin
    assert_disjoint_R9: assert (!(cfg_hit && mgmt_hit));
  end

endmodule

// File: rtl/l2cls_index_sizer.sv
module l2cls_index_sizer
  import l2cls_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int CFG_W = 4
) (
  input  logic [IDX_W-1:0] raw_idx,
  input  logic [CFG_W-1:0] cfg,
  output logic [IDX_W-1:0] sized_idx,
  output logic             unsupported
);

  localparam int NFLD = CFG_W / 2;
  localparam int KEEP = IDX_W - NFLD;

  logic [NFLD-1:0] act;
  logic [NFLD-1:0] bad;

  assign sized_idx[KEEP-1:0] = raw_idx[KEEP-1:0];

  // Field k acts on index bit IDX_W-1-k.
  for (genvar k = 0; k < NFLD; k++) begin : g_fld
    logic [1:0] f;
    assign f      = cfg[2*k+1:2*k];
    assign act[k] = fld_active(f);
    assign sized_idx[IDX_W-1-k] = act[k] ? fld_level(f) : raw_idx[IDX_W-1-k];
    if (k == 0) begin : g_first
      assign bad[k] = fld_bad(f);
    end else begin : g_rest
      // A lower field may only restrict when the one above it also does.
      assign bad[k] = fld_bad(f) || (act[k] && !act[k-1]);
    end

    always_comb begin
      assert_pin_low_R4: assert (!(f == 2'd1) || (sized_idx[IDX_W-1-k] == 1'b0));
      assert_pin_high_R4: assert (!(f == 2'd2) || (sized_idx[IDX_W-1-k] == 1'b1));
    end
  end

  assign unsupported = |bad;

  always_comb begin
    assert_full_pass_R3: assert (!(cfg == '0) || (sized_idx == raw_idx));
  end

endmodule

// File: rtl/l2_addr_classifier.sv
module l2_addr_classifier #(
  parameter int          ADDR_W    = 40,
  parameter int          LINE_LOG2 = 5,
  parameter int          IDX_W     = 12,
  parameter int          WAY_W     = 2,
  parameter int          CFG_W     = 4,
  parameter int          CFG_LSB   = 8,
  parameter logic [39:0] CFG_ADDR  = 40'h00_1004_2000,
  parameter logic [39:0] MGMT_BASE = 40'h00_D000_0000,
  parameter int          MGMT_LOG2 = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cacheable,
  output logic [IDX_W-1:0]  idx_out,
  output logic [WAY_W-1:0]  mgmt_way,
  output logic              is_cfg_wr,
  output logic              is_mgmt,
  output logic              is_normal,
  output logic              force_hit,
  output logic              mc_ignore,
  output logic              eff_cacheable,
  output logic              fwd_vld,
  output logic [CFG_W-1:0]  cfg_readback,
  output logic              cfg_unsupported
);

  localparam int IDX_LSB = LINE_LOG2;
  localparam int WAY_LSB = LINE_LOG2 + IDX_W;

  logic             cfg_hit;
  logic             mgmt_hit;
  logic [CFG_W-1:0] cfg_nib;
  logic [CFG_W-1:0] cfg_q;
  logic [IDX_W-1:0] raw_idx;
  logic [IDX_W-1:0] sized_idx;
  logic             cfg_load;

  l2cls_addr_match #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CFG_LSB(CFG_LSB), .CFG_W(CFG_W),
    .MGMT_BASE(MGMT_BASE), .MGMT_LOG2(MGMT_LOG2), .WAY_LSB(WAY_LSB), .WAY_W(WAY_W)
  ) u_match (
    .addr(req_addr), .cfg_hit(cfg_hit), .cfg_nib(cfg_nib),
    .mgmt_hit(mgmt_hit), .way_sel(mgmt_way)
  );

  assign cfg_load = req_vld && req_wr && cfg_hit;

  l2cls_sizereg #(.CFG_W(CFG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load_en(cfg_load), .load_val(cfg_nib), .cfg_q(cfg_q)
  );

  assign raw_idx = req_addr[IDX_LSB+IDX_W-1:IDX_LSB];

  l2cls_index_sizer #(.IDX_W(IDX_W), .CFG_W(CFG_W)) u_size (
    .raw_idx(raw_idx), .cfg(cfg_q), .sized_idx(sized_idx), .unsupported(cfg_unsupported)
  );

  assign is_cfg_wr     = cfg_load;
  assign is_mgmt       = req_vld && mgmt_hit && !cfg_load;
  assign is_normal     = req_vld && !cfg_load && !is_mgmt;
  assign force_hit     = is_mgmt;
  assign mc_ignore     = is_mgmt;
  assign eff_cacheable = is_mgmt || req_cacheable;
  assign fwd_vld       = req_vld && !cfg_load;
  assign idx_out       = is_mgmt ? raw_idx : sized_idx;
  assign cfg_readback  = cfg_q;

  assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |-> $onehot({is_cfg_wr, is_mgmt, is_normal}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |-> !(is_cfg_wr || is_mgmt || is_normal || force_hit || mc_ignore || fwd_vld));

  assert_mgmt_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_mgmt |-> (force_hit && mc_ignore && eff_cacheable && fwd_vld));

  assert_cfg_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_cfg_wr |-> !fwd_vld);

endmodule

// File: tb/l2_addr_classifier_tb.sv
module l2_addr_classifier_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_wr = 1'b0;
  logic [39:0] req_addr = '0;
  logic        req_cacheable = 1'b0;
  logic [11:0] idx_out;
  logic [1:0]  mgmt_way;
  logic        is_cfg_wr, is_mgmt, is_normal, force_hit, mc_ignore;
  logic        eff_cacheable, fwd_vld, cfg_unsupported;
  logic [3:0]  cfg_readback;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  l2_addr_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_cacheable(req_cacheable),
    .idx_out(idx_out), .mgmt_way(mgmt_way), .is_cfg_wr(is_cfg_wr),
    .is_mgmt(is_mgmt), .is_normal(is_normal), .force_hit(force_hit),
    .mc_ignore(mc_ignore), .eff_cacheable(eff_cacheable), .fwd_vld(fwd_vld),
    .cfg_readback(cfg_readback), .cfg_unsupported(cfg_unsupported)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a request just after a falling edge and let it settle.
  task automatic drive(input logic v, input logic w, input logic [39:0] a, input logic c);
    @(negedge clk);
    req_vld = v; req_wr = w; req_addr = a; req_cacheable = c;
    #1;
  endtask

  function automatic logic [39:0] cfg_addr(input logic [3:0] n);
    return 40'h00_1004_2000 | ({36'd0, n} << 8);
  endfunction

  // Load a size setting and return to idle.
  task automatic set_size(input logic [3:0] n);
    drive(1'b1, 1'b1, cfg_addr(n), 1'b0);
    drive(1'b0, 1'b0, 40'd0, 1'b0);
  endtask

  // Expected index under a supported setting, written as a lookup.
  function automatic logic [11:0] exp_idx(input logic [3:0] n, input logic [39:0] a);
    logic [11:0] r;
    r = a[16:5];
    case (n)
      4'h1: r[11] = 1'b0;
      4'h2: r[11] = 1'b1;
      4'h5: begin r[11] = 1'b0; r[10] = 1'b0; end
      4'h6: begin r[11] = 1'b1; r[10] = 1'b0; end
      4'h9: begin r[11] = 1'b0; r[10] = 1'b1; end
      4'hA: begin r[11] = 1'b1; r[10] = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 readback", {36'd0, cfg_readback}, 40'd0);
    chk("R1 unsupported", {39'd0, cfg_unsupported}, 40'd0);
    chk("R9 idle flags", {34'd0, is_cfg_wr, is_mgmt, is_normal, force_hit, mc_ignore, fwd_vld}, 40'd0);
  endtask

  task automatic t_cfg_load;
    drive(1'b1, 1'b1, cfg_addr(4'h6), 1'b0);
    chk("R2 not before edge", {36'd0, cfg_readback}, 40'd0);
    chk("R10 cfg not forwarded", {38'd0, is_cfg_wr, fwd_vld}, 40'd2);
    chk("R9 cfg one class", {37'd0, is_cfg_wr, is_mgmt, is_normal}, 40'd4);
    drive(1'b0, 1'b0, 40'd0, 1'b0);
    chk("R2 loaded", {36'd0, cfg_readback}, 40'd6);
    // read of cfg address: normal, no load
    drive(1'b1, 1'b0, cfg_addr(4'h1), 1'b1);
    chk("R10 cfg read normal", {37'd0, is_normal, fwd_vld, is_cfg_wr}, 40'd6);
    drive(1'b0, 1'b0, 40'd0, 1'b0);
    chk("R2 read no load", {36'd0, cfg_readback}, 40'd6);
    // single-bit-off addresses
    drive(1'b1, 1'b1, cfg_addr(4'h1) | 40'h1, 1'b0);
    chk("R2 low byte mismatch", {39'd0, is_cfg_wr}, 40'd0);
    drive(1'b1, 1'b1, cfg_addr(4'h1) ^ 40'h00_0000_1000, 1'b0);
    chk("R2 bit12 mismatch", {39'd0, is_cfg_wr}, 40'd0);
    drive(1'b0, 1'b0, 40'd0, 1'b0);
    chk("R11 held", {36'd0, cfg_readback}, 40'd6);
  endtask

  task automatic t_sizes;
    logic [39:0] pats [4];
    logic [3:0]  vals [7];
    pats[0] = 40'h00_0001_FFE0; pats[1] = 40'h00_0000_0000;
    pats[2] = 40'h12_3450_AAA0; pats[3] = 40'h00_0001_5540;
    vals[0] = 4'h0; vals[1] = 4'h1; vals[2] = 4'h2; vals[3] = 4'h5;
    vals[4] = 4'h6; vals[5] = 4'h9; vals[6] = 4'hA;
    for (int v = 0; v < 7; v++) begin
      set_size(vals[v]);
      chk("R6 supported", {39'd0, cfg_unsupported}, 40'd0);
      for (int p = 0; p < 4; p++) begin
        drive(1'b1, 1'b0, pats[p], 1'b1);
        if (vals[v] == 0)      chk("R3 full index", {28'd0, idx_out}, {28'd0, exp_idx(vals[v], pats[p])});
        else if (vals[v] < 3)  chk("R4 half index", {28'd0, idx_out}, {28'd0, exp_idx(vals[v], pats[p])});
        else                   chk("R5 quarter index", {28'd0, idx_out}, {28'd0, exp_idx(vals[v], pats[p])});
      end
    end
    drive(1'b0, 1'b0, 40'd0, 1'b0);
  endtask

  task automatic t_unsup;
    for (int n = 0; n < 16; n++) begin
      logic exp_u;
      exp_u = !(n == 0 || n == 1 || n == 2 || n == 5 || n == 6 || n == 9 || n == 10);
      set_size(n[3:0]);
      chk("R6 unsupported flag", {39'd0, cfg_unsupported}, {39'd0, exp_u});
    end
  endtask

  task automatic t_mgmt;
    set_size(4'h5);
    drive(1'b1, 1'b0, 40'h00_D000_0000, 1'b0);
    chk("R7 low edge in", {36'd0, is_mgmt, force_hit, mc_ignore, eff_cacheable}, 40'hF);
    drive(1'b1, 1'b1, 40'h00_D7FF_FFFF, 1'b0);
    chk("R7 high edge in", {38'd0, is_mgmt, fwd_vld}, 40'd3);
    chk("R8 way", {38'd0, mgmt_way}, 40'd3);
    chk("R8 raw index", {28'd0, idx_out}, 40'hFFF);
    drive(1'b1, 1'b0, 40'h00_CFFF_FFFF, 1'b0);
    chk("R7 below window", {36'd0, is_mgmt, is_normal, force_hit, eff_cacheable}, 40'h4);
    chk("R5 normal still sized", {28'd0, idx_out}, 40'h3FF);
    drive(1'b1, 1'b0, 40'h00_D800_0000, 1'b1);
    chk("R7 above window", {38'd0, is_mgmt, mc_ignore}, 40'd0);
    drive(1'b1, 1'b1, 40'h00_D004_AAA0, 1'b0);
    chk("R8 way 2", {38'd0, mgmt_way}, 40'd2);
    chk("R8 index", {28'd0, idx_out}, 40'h555);
    drive(1'b0, 1'b0, 40'd0, 1'b0);
    chk("R11 mgmt no load", {36'd0, cfg_readback}, 40'd5);
    chk("R9 idle after", {35'd0, is_cfg_wr, is_mgmt, is_normal, force_hit, fwd_vld}, 40'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_cfg_load();
        t_sizes();
        t_unsup();
        t_mgmt();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule